// File: doc/BRIEF.md
# Min-Selector Dot-Product Accumulator

This block is the arithmetic core of a multiplier-free neuron. On each accepted cycle it takes one activation and one weight, each in sign-magnitude form. It turns the pair into an approximate product without any multiplier. The magnitude of the term is the smaller of the two operand magnitudes, found by one magnitude comparison that steers a 2:1 select. The sign of the term comes from whether the two sign bits agree. The signed term is added into a two's-complement running sum.

A vector is framed by two markers on the input cycles. A first marker starts a fresh sum, and a last marker ends the vector. One cycle after the last element is accepted, the finished sum appears on the output with a single-cycle valid strobe. Input gaps inside a vector are allowed. The sum clamps at its numeric limits instead of wrapping around. An upstream sequencer streams the operand pairs in, and a downstream activation stage picks up each finished sum.

Top module: `mds_dot`

## Requirements
- R1: The magnitude of each term is the smaller of the two operand magnitudes, where bits [DATA_W-2:0] of each operand hold the magnitude. Equal magnitudes give that common value.
- R2: Bit DATA_W-1 of each operand is its sign, with 1 meaning negative. If the two sign bits are equal, the term is added. If they differ, the term is subtracted.
- R3: A term whose selected magnitude is zero adds nothing, including when one operand is a negative zero (sign 1, magnitude 0).
- R4: An accepted cycle with in_first high discards the previous sum, so the new sum equals that cycle's term alone.
- R5: An accepted cycle with in_last high sets out_valid high for exactly the next cycle. In that cycle out_sum holds the sum including that term. A vector that is both first and last is allowed, and back-to-back vectors give back-to-back strobes.
- R6: A cycle with in_valid low changes neither the running sum nor the outputs. In such a cycle in_first and in_last have no effect.
- R7: The running sum is ACC_W = DATA_W-1+GUARD_W bits wide (16 by default). A positive overflow clamps it at 2^(ACC_W-1)-1, and it does not wrap.
- R8: A negative overflow clamps the running sum at -2^(ACC_W-1), and it does not wrap.
- R9: A synchronous active-high rst clears the running sum, out_sum and out_valid. A vector interrupted by rst resumes from zero.
- R10: out_sum keeps the last presented value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_first | input | 1 | Pair opens a new vector |
| in_last | input | 1 | Pair closes the vector |
| act | input | DATA_W | Activation, sign-magnitude |
| wgt | input | DATA_W | Weight, sign-magnitude |
| out_valid | output | 1 | One-cycle strobe: out_sum is a finished sum |
| out_sum | output | ACC_W | Finished sum, two's complement |

## Verification
Several properties are checked on every cycle. The selected magnitude is never larger than either operand and always equals one of them. A zero magnitude never carries a negative sign. An idle cycle leaves the running sum unchanged. A first-marked term replaces the sum outright. The strobe follows an accepted last marker by exactly one cycle. The sum stays pinned once it sits at a limit and the incoming term pushes further out. Only the bench scenarios can show the rest: the actual totals of mixed-sign vectors, that out_sum holds steady between strobes, and that the 300-term runs to both clamp values followed by a term back toward zero leave the correct result. They also show recovery from a reset in the middle of a vector.

// File: rtl/mds_pkg.sv
package mds_pkg;

    // Default operand width (sign + magnitude) and accumulator guard bits
    localparam int DEF_DATA_W  = 8;
    localparam int DEF_GUARD_W = 9;

    // Direction in which the adder result left the representable range
    typedef enum logic [1:0] {
        SAT_NONE = 2'b00,
        SAT_HI   = 2'b01,
        SAT_LO   = 2'b10
    } sat_e;

    // One approximate product term in sign-magnitude form
    typedef struct packed {
        logic                    neg;
        logic [DEF_DATA_W-2:0]   mag;
    } term_t;

endpackage

// File: rtl/mds_term.sv
module mds_term #(
    parameter int DATA_W = mds_pkg::DEF_DATA_W,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              term_neg,
    output logic [MAG_W-1:0]  term_mag
);

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             a_smaller;
    logic             sign_differ;

    assign mag_a = op_a[MAG_W-1:0];
    assign mag_b = op_b[MAG_W-1:0];

    // Magnitude comparator drives the select of a 2:1 mux
    assign a_smaller = (mag_a < mag_b);
    assign term_mag  = a_smaller ? mag_a : mag_b;

    // Sign agreement: XOR of the sign bits, suppressed for a zero term
    assign sign_differ = op_a[DATA_W-1] ^ op_b[DATA_W-1];
    assign term_neg    = sign_differ && (term_mag != '0);

endmodule

// File: rtl/mds_accum.sv
module mds_accum #(
    parameter int MAG_W = mds_pkg::DEF_DATA_W - 1,
    parameter int ACC_W = MAG_W + mds_pkg::DEF_GUARD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             first,
    input  logic             term_neg,
    input  logic [MAG_W-1:0] term_mag,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_d
);
    import mds_pkg::*;

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] term_ext;
    logic [ACC_W-1:0] term_signed;
    logic [ACC_W:0]   wide_sum;
    sat_e             sat_dir;
    logic [ACC_W-1:0] clamped;

    assign base        = first ? '0 : acc_q;
    assign term_ext    = {{(ACC_W-MAG_W){1'b0}}, term_mag};
    assign term_signed = term_neg ? (~term_ext + 1'b1) : term_ext;
    assign wide_sum    = {base[ACC_W-1], base} + {term_signed[ACC_W-1], term_signed};

    always_comb begin
        if (wide_sum[ACC_W] == wide_sum[ACC_W-1]) begin
            sat_dir = SAT_NONE;
        end else if (wide_sum[ACC_W]) begin
            sat_dir = SAT_LO;
        end else begin
            sat_dir = SAT_HI;
        end
    end

    always_comb begin
        unique case (sat_dir)
            SAT_HI:  clamped = ACC_MAX;
            SAT_LO:  clamped = ACC_MIN;
            default: clamped = wide_sum[ACC_W-1:0];
        endcase
    end

    assign acc_d = en ? clamped : acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/mds_present.sv
module mds_present #(
    parameter int ACC_W = mds_pkg::DEF_DATA_W - 1 + mds_pkg::DEF_GUARD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [ACC_W-1:0] sum_in,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_sum
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_sum <= sum_in;
            end
        end
    end

endmodule

// File: rtl/mds_dot.sv
module mds_dot #(
    parameter int DATA_W  = mds_pkg::DEF_DATA_W,
    parameter int GUARD_W = mds_pkg::DEF_GUARD_W,
    localparam int MAG_W  = DATA_W - 1,
    localparam int ACC_W  = MAG_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [DATA_W-1:0] act,
    input  logic [DATA_W-1:0] wgt,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_sum
);

    logic             term_neg;
    logic [MAG_W-1:0] term_mag;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;
    logic             fire;

    mds_term #(.DATA_W(DATA_W)) u_term (
        .op_a     (act),
        .op_b     (wgt),
        .term_neg (term_neg),
        .term_mag (term_mag)
    );

    mds_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid),
        .first    (in_first),
        .term_neg (term_neg),
        .term_mag (term_mag),
        .acc_q    (acc),
        .acc_d    (acc_next)
    );

    assign fire = in_valid && in_last;

    mds_present #(.ACC_W(ACC_W)) u_present (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .sum_in    (acc_next),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

endmodule

// File: rtl/mds_dot_chk.sv
module mds_dot_chk #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16,
    localparam int MAG_W = DATA_W - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_last,
    input logic [DATA_W-1:0] act,
    input logic [DATA_W-1:0] wgt,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_sum,
    input logic              term_neg,
    input logic [MAG_W-1:0]  term_mag,
    input logic [ACC_W-1:0]  acc
);

    localparam logic [ACC_W-1:0] TOP_VAL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] BOT_VAL = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] t_ext;
    assign t_ext = {{(ACC_W-MAG_W){1'b0}}, term_mag};

    // R1
    min_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (term_mag <= act[MAG_W-1:0]) && (term_mag <= wgt[MAG_W-1:0]) &&
        ((term_mag == act[MAG_W-1:0]) || (term_mag == wgt[MAG_W-1:0])));

    // R3
    zero_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (term_mag == '0) |-> !term_neg);

    // R4
    first_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first) |=>
        (acc == ($past(term_neg) ? (~$past(t_ext) + 1'b1) : $past(t_ext))));

    // R5
    strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && in_last && !rst));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> $stable(acc));

    // R7
    pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_first && !term_neg && acc == TOP_VAL) |=> acc == TOP_VAL);

    // R8
    neg_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_first && term_neg && acc == BOT_VAL) |=> acc == BOT_VAL);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sum == '0 && acc == '0));

endmodule

bind mds_dot mds_dot_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .act       (act),
    .wgt       (wgt),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .term_neg  (term_neg),
    .term_mag  (term_mag),
    .acc       (acc)
);

// File: tb/tb_mds_dot.sv
module tb_mds_dot;

    localparam int DW = 8;
    localparam int AW = 16;
    localparam int ROWS = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_first = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] act = '0;
    logic [DW-1:0] wgt = '0;
    logic          out_valid;
    logic [AW-1:0] out_sum;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mds_dot dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .act(act), .wgt(wgt),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    typedef struct packed {
        logic          v;
        logic          f;
        logic          l;
        logic [DW-1:0] a;
        logic [DW-1:0] w;
        logic          ov;
        logic [AW-1:0] s;
    } row_t;

    // sign in bit 7 (1 = negative), magnitude in bits 6:0
    localparam logic [36:0] TBL [0:ROWS-1] = '{
        {3'b110, 8'h0A, 8'h03, 1'b0, 16'h0000, 1'b0}, // R1 +3
        {3'b100, 8'h94, 8'h07, 1'b0, 16'h0000, 1'b0}, // R2 -7 -> -4
        {3'b011, 8'h7F, 8'h7F, 1'b0, 16'h0000, 1'b0}, // R6 idle
        {3'b101, 8'h85, 8'h89, 1'b1, 16'h0001, 1'b0}, // R2 +5 -> 1, R5
        {3'b111, 8'h06, 8'h86, 1'b1, 16'hFFFA, 1'b0}, // R1 equal, R4 -6
        {3'b110, 8'h80, 8'h85, 1'b0, 16'hFFFA, 1'b0}, // R3 -0
        {3'b100, 8'h00, 8'h85, 1'b0, 16'hFFFA, 1'b0}, // R3 +0
        {3'b100, 8'h90, 8'h80, 1'b0, 16'hFFFA, 1'b0}, // R3 -16,-0
        {3'b101, 8'h7F, 8'h7F, 1'b1, 16'h007F, 1'b0}, // R5 127
        {3'b000, 8'h11, 8'h22, 1'b0, 16'h007F, 1'b0}, // R10 hold
        {3'b110, 8'hFF, 8'h01, 1'b0, 16'h007F, 1'b0}, // R1 -1
        {3'b100, 8'h64, 8'hE4, 1'b0, 16'h007F, 1'b0}, // R2 -100
        {3'b101, 8'h02, 8'h81, 1'b1, 16'hFF9A, 1'b0}, // R5 -102
        {3'b111, 8'h33, 8'h21, 1'b1, 16'h0021, 1'b0}, // R4 +33
        {3'b001, 8'h44, 8'h55, 1'b0, 16'h0021, 1'b0}  // R6 last ignored
    };

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // drive on the falling edge, outputs then checked one falling edge later
    task automatic drive(input logic v, input logic f, input logic l,
                         input logic [DW-1:0] a, input logic [DW-1:0] w);
        in_valid = v; in_first = f; in_last = l; act = a; wgt = w;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        row_t r;
        @(negedge clk); @(negedge clk);
        check("R9 reset valid", {15'b0, out_valid}, 16'h0);
        check("R9 reset sum", out_sum, 16'h0);
        rst = 1'b0;

        for (int i = 0; i < ROWS; i++) begin
            r = row_t'(TBL[i][36:1]);
            drive(r.v, r.f, r.l, r.a, r.w);
            check($sformatf("R5 row %0d valid", i), {15'b0, out_valid}, {15'b0, r.ov});
            check($sformatf("R1/R2/R3 row %0d sum", i), out_sum, r.s);
        end

        // R9: reset in the middle of a vector
        drive(1'b1, 1'b1, 1'b0, 8'h32, 8'h32);
        rst = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 8'h7F, 8'h7F);
        check("R9 mid reset valid", {15'b0, out_valid}, 16'h0);
        check("R9 mid reset sum", out_sum, 16'h0);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 8'h04, 8'h09);
        check("R9 resume valid", {15'b0, out_valid}, 16'h1);
        check("R9 resume sum", out_sum, 16'h0004);

        // R7: 300 terms of +127, then last
        for (int k = 0; k < 300; k++) drive(1'b1, k == 0, k == 299, 8'h7F, 8'h7F);
        check("R7 pos clamp", out_sum, 16'h7FFF);
        drive(1'b1, 1'b0, 1'b1, 8'h81, 8'h05);
        check("R7 no wrap after clamp", out_sum, 16'h7FFE);

        // R8: 300 terms of -127
        for (int k = 0; k < 300; k++) drive(1'b1, k == 0, k == 299, 8'hFF, 8'h7F);
        check("R8 neg clamp", out_sum, 16'h8000);
        drive(1'b1, 1'b0, 1'b1, 8'h01, 8'h03);
        check("R8 no wrap after clamp", out_sum, 16'h8001);

        // R5: strobe lasts a single cycle
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        check("R5 strobe single", {15'b0, out_valid}, 16'h0);
        check("R10 hold", out_sum, 16'h8001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule